// File: doc/BRIEF.md
# Display List Entry Walker

The walker runs one sequencer per output channel. Each sequencer follows a chain of variable-length entries held in a shared, word-addressed list memory. A channel is armed by writing its start word index. From that point it reads a header word, passes the header and the body words of that entry to a downstream consumer, and then jumps by the header's size field to the next header. A header carrying the end flag ends the walk for that frame. A header that is malformed or that points past the top of memory ends the walk with a sticky per-channel error.

All channels share one synchronous read port, which has one cycle of read latency. A round-robin arbiter grants that port to one walking channel per cycle, and each channel may have at most one read in flight. Every word delivered to the consumer is tagged with its channel, its word index and a strobe that marks the first word of an entry. The block does not interpret the body words.

Top module: `dlw_walker`

## Requirements
- R1: While reset is high, and in the first cycle after it, every channel reports mode OFF (code 0) with its error flag clear, `out_valid` is low and `mem_rd_en` is low.
- R2: A write with `cfg_we` high to a channel index below NUM_CH sets that channel's walk pointer to `cfg_start` and clears its error flag. With `cfg_run` = 1 the mode becomes WALK (code 1). With `cfg_run` = 0 the mode becomes OFF, and no further word of that channel appears. A write to an index of NUM_CH or above changes nothing. The walk may start anywhere in memory, including the low reserved words.
- R3: A header word has the end flag in bit 31 and the advance size in bits 29:24. A header with the end flag clear and a nonzero size is output with `out_entry_start` = 1. The next size-1 words follow, in increasing address order, with `out_entry_start` = 0. The next header is then read at header index + size.
- R4: Only header positions are tested for the end flag. A body word with bit 31 set is output like any other body word.
- R5: A header with the end flag set is not output. The channel's mode becomes EOF (code 2) and the channel issues no further reads.
- R6: Only channels in mode WALK issue memory reads. OFF and EOF channels are skipped.
- R7: A header with size 0 and the end flag clear is not output. It sets the channel's error flag and puts the channel in mode OFF.
- R8: A header whose index + size exceeds the last memory word is not output. It sets the channel's error flag and puts the channel in mode OFF; the pointer does not wrap.
- R9: At most one read is issued per cycle, and a channel never has two reads in flight. Walking channels are served round-robin. A lone channel therefore delivers one word every 2 cycles, and three walking channels deliver words in the order 0,1,2,0,1,2.
- R10: A word read in cycle t appears at the output in cycle t+2, carrying the read index, the memory word unchanged and the channel that issued the read. After a run write, the first word appears 3 cycles after the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Channel configuration write strobe |
| cfg_ch | input | CH_W | Channel addressed by the write |
| cfg_start | input | AW | Start word index of the list |
| cfg_run | input | 1 | 1 starts a walk, 0 stops the channel |
| ch_state | output | 2*NUM_CH | Per-channel mode, 2 bits per channel (0 OFF, 1 WALK, 2 EOF) |
| ch_err | output | NUM_CH | Per-channel sticky error flag |
| mem_rd_en | output | 1 | List memory read request |
| mem_rd_addr | output | AW | List memory word index |
| mem_rd_data | input | 32 | Read data, valid the cycle after the request |
| out_valid | output | 1 | Output word valid |
| out_ch | output | CH_W | Channel of the output word |
| out_idx | output | AW | Word index of the output word |
| out_data | output | 32 | Output word |
| out_entry_start | output | 1 | Output word is an entry header |

## Verification
Several properties are checked on every cycle. Reads come only from walking channels. No channel issues reads on consecutive cycles. Every output word matches, two cycles later, the read that produced it. No emitted header carries the end flag or a zero size. An error flag only rises together with the OFF mode, and an EOF channel is silent. Other behaviour needs the bench's scenarios. These cover the exact word order of a chained list, the round-robin order across three channels and the single-channel spacing. They also cover the stop and ignored-write cases, which can only be judged against lists that the bench walks on its own, and the difference between an entry that ends exactly at the last word and one that overruns it.

// File: rtl/dlw_pkg.sv
package dlw_pkg;

    // List word layout (header fields decoded by the walker)
    localparam int WORD_W   = 32;
    localparam int END_BIT  = 31;
    localparam int SIZE_LSB = 24;
    localparam int SIZE_W   = 6;

    typedef logic [WORD_W-1:0] word_t;

    // Per-channel walk mode, as reported on ch_state
    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,
        CH_WALK = 2'd1,
        CH_EOF  = 2'd2
    } ch_mode_e;

    // Action taken on a returned read
    typedef enum logic [2:0] {
        ACT_NONE  = 3'd0,
        ACT_ENTER = 3'd1,
        ACT_BODY  = 3'd2,
        ACT_EOF   = 3'd3,
        ACT_FAULT = 3'd4
    } ret_act_e;

    // Result of decoding one returned read
    typedef struct packed {
        ret_act_e act;
        logic     emit;
        logic     first;
    } ret_t;

    function automatic logic is_stop(ret_act_e a);
        return (a == ACT_EOF) || (a == ACT_FAULT);
    endfunction

endpackage

// File: rtl/dlw_rr_arb.sv
// Round-robin grant among requesting channels; one grant per cycle (R9).
module dlw_rr_arb #(
    parameter int N  = 3,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    output logic          gnt_valid,
    output logic [IW-1:0] gnt_idx
);

    logic [IW-1:0] last_q;

    always_comb begin
        int cand;
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        cand      = 0;
        for (int k = 1; k <= N; k++) begin
            cand = (int'(last_q) + k) % N;
            if (!gnt_valid && req[cand]) begin
                gnt_valid = 1'b1;
                gnt_idx   = IW'(cand);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= IW'(N - 1);
        end else if (gnt_valid) begin
            last_q <= gnt_idx;
        end
    end

endmodule

// File: rtl/dlw_chan_ctx.sv
// Per-channel walk context: mode, error, pointer, header tracking.
module dlw_chan_ctx
    import dlw_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_hit,
    input  logic          cfg_run,
    input  logic [AW-1:0] cfg_start,
    input  logic          ret_hit,
    input  ret_act_e      ret_act,
    input  logic [AW-1:0] ret_tgt,
    output ch_mode_e      mode,
    output logic          err,
    output logic [AW-1:0] cur,
    output logic          at_hdr
);

    logic [AW-1:0] nhdr_q;
    logic [AW-1:0] step;

    assign step = cur + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= CH_OFF;
            err    <= 1'b0;
            cur    <= '0;
            at_hdr <= 1'b1;
            nhdr_q <= '0;
        end else if (cfg_hit) begin
            // R2: configuration write wins over any returning read
            cur    <= cfg_start;
            at_hdr <= 1'b1;
            err    <= 1'b0;
            mode   <= cfg_run ? CH_WALK : CH_OFF;
        end else if (ret_hit) begin
            case (ret_act)
                ACT_ENTER: begin
                    nhdr_q <= ret_tgt;
                    cur    <= step;
                    at_hdr <= (step == ret_tgt);
                end
                ACT_BODY: begin
                    cur    <= step;
                    at_hdr <= (step == nhdr_q);
                end
                ACT_EOF: begin
                    mode <= CH_EOF;          // R5
                end
                ACT_FAULT: begin
                    mode <= CH_OFF;          // R7, R8
                    err  <= 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/dlw_ret_dec.sv
// Classifies the word returned by the list memory.
module dlw_ret_dec
    import dlw_pkg::*;
#(
    parameter int AW        = 12,
    parameter int MEM_WORDS = 4096
) (
    input  logic              pend_valid,
    input  logic              pend_hdr,
    input  logic              kill,
    input  logic [AW-1:0]     pend_addr,
    input  logic              hdr_last,
    input  logic [SIZE_W-1:0] hdr_size,
    output ret_t              ret,
    output logic [AW-1:0]     tgt
);

    localparam logic [AW:0] LAST_IDX = (AW+1)'(MEM_WORDS - 1);

    logic [AW:0] sum;

    assign sum = {1'b0, pend_addr} + (AW+1)'(hdr_size);
    assign tgt = sum[AW-1:0];

    always_comb begin
        ret = '{act: ACT_NONE, emit: 1'b0, first: 1'b0};
        if (pend_valid && !kill) begin
            if (!pend_hdr) begin
                // R4: body words are never tested for the end flag
                ret = '{act: ACT_BODY, emit: 1'b1, first: 1'b0};
            end else if (hdr_last) begin
                ret.act = ACT_EOF;                       // R5
            end else if (hdr_size == '0 || sum > LAST_IDX) begin
                ret.act = ACT_FAULT;                     // R7, R8
            end else begin
                ret = '{act: ACT_ENTER, emit: 1'b1, first: 1'b1};  // R3
            end
        end
    end

endmodule

// File: rtl/dlw_walker.sv
module dlw_walker
    import dlw_pkg::*;
#(
    parameter int   NUM_CH    = 3,
    parameter int   MEM_WORDS = 4096,
    localparam int  CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int  AW        = $clog2(MEM_WORDS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [CH_W-1:0]       cfg_ch,
    input  logic [AW-1:0]         cfg_start,
    input  logic                  cfg_run,
    output logic [2*NUM_CH-1:0]   ch_state,
    output logic [NUM_CH-1:0]     ch_err,
    output logic                  mem_rd_en,
    output logic [AW-1:0]         mem_rd_addr,
    input  logic [WORD_W-1:0]     mem_rd_data,
    output logic                  out_valid,
    output logic [CH_W-1:0]       out_ch,
    output logic [AW-1:0]         out_idx,
    output logic [WORD_W-1:0]     out_data,
    output logic                  out_entry_start
);

    // Per-channel context
    ch_mode_e            mode_v [NUM_CH];
    logic [NUM_CH-1:0]   err_v;
    logic [AW-1:0]       cur_v  [NUM_CH];
    logic [NUM_CH-1:0]   hdr_v;
    logic [NUM_CH-1:0]   cfg_hit;
    logic [NUM_CH-1:0]   ret_hit;
    logic [NUM_CH-1:0]   req;

    // Arbitration and in-flight read
    logic                sel_valid;
    logic [CH_W-1:0]     sel_ch;
    logic                sel_hdr;
    logic                pend_valid;
    logic [CH_W-1:0]     pend_ch;
    logic [AW-1:0]       pend_addr;
    logic                pend_hdr;
    logic                kill;

    // Return decode
    ret_t                ret;
    logic [AW-1:0]       ret_tgt;

    assign kill = cfg_we && (cfg_ch == pend_ch);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign cfg_hit[c] = cfg_we && (cfg_ch == CH_W'(c));
        assign ret_hit[c] = pend_valid && (pend_ch == CH_W'(c));
        // R6, R9: only walking channels with nothing in flight may request
        assign req[c] = (mode_v[c] == CH_WALK) && !cfg_hit[c] && !ret_hit[c];

        dlw_chan_ctx #(.AW(AW)) u_ctx (
            .clk       (clk),
            .rst       (rst),
            .cfg_hit   (cfg_hit[c]),
            .cfg_run   (cfg_run),
            .cfg_start (cfg_start),
            .ret_hit   (ret_hit[c]),
            .ret_act   (ret.act),
            .ret_tgt   (ret_tgt),
            .mode      (mode_v[c]),
            .err       (err_v[c]),
            .cur       (cur_v[c]),
            .at_hdr    (hdr_v[c])
        );

        assign ch_state[2*c +: 2] = mode_v[c];
    end

    assign ch_err = err_v;

    dlw_rr_arb #(.N(NUM_CH), .IW(CH_W)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .gnt_valid (sel_valid),
        .gnt_idx   (sel_ch)
    );

    always_comb begin
        mem_rd_addr = '0;
        sel_hdr     = 1'b0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (sel_ch == CH_W'(c)) begin
                mem_rd_addr = cur_v[c];
                sel_hdr     = hdr_v[c];
            end
        end
    end

    assign mem_rd_en = sel_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_valid <= 1'b0;
            pend_ch    <= '0;
            pend_addr  <= '0;
            pend_hdr   <= 1'b0;
        end else begin
            pend_valid <= sel_valid;
            pend_ch    <= sel_ch;
            pend_addr  <= mem_rd_addr;
            pend_hdr   <= sel_hdr;
        end
    end

    dlw_ret_dec #(.AW(AW), .MEM_WORDS(MEM_WORDS)) u_dec (
        .pend_valid (pend_valid),
        .pend_hdr   (pend_hdr),
        .kill       (kill),
        .pend_addr  (pend_addr),
        .hdr_last   (mem_rd_data[END_BIT]),
        .hdr_size   (mem_rd_data[SIZE_LSB +: SIZE_W]),
        .ret        (ret),
        .tgt        (ret_tgt)
    );

    // R10: returned word is registered once more before leaving the block
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid       <= 1'b0;
            out_ch          <= '0;
            out_idx         <= '0;
            out_data        <= '0;
            out_entry_start <= 1'b0;
        end else begin
            out_valid       <= ret.emit;
            out_ch          <= pend_ch;
            out_idx         <= pend_addr;
            out_data        <= mem_rd_data;
            out_entry_start <= ret.first;
        end
    end

endmodule

// File: rtl/dlw_walker_chk.sv
module dlw_walker_chk
    import dlw_pkg::*;
#(
    parameter int   NUM_CH    = 3,
    parameter int   MEM_WORDS = 4096,
    localparam int  CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int  AW        = $clog2(MEM_WORDS)
) (
    input logic                clk,
    input logic                rst,
    input logic [2*NUM_CH-1:0] ch_state,
    input logic [NUM_CH-1:0]   ch_err,
    input logic                mem_rd_en,
    input logic [AW-1:0]       mem_rd_addr,
    input logic [CH_W-1:0]     sel_ch,
    input logic                out_valid,
    input logic [CH_W-1:0]     out_ch,
    input logic [AW-1:0]       out_idx,
    input logic                out_end_bit,
    input logic [SIZE_W-1:0]   out_size,
    input logic                out_entry_start
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (ch_state == '0 && ch_err == '0 && !out_valid));

    assert_read_only_walking_R6: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> (ch_state[2*sel_ch +: 2] == CH_WALK));

    assert_single_in_flight_R9: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !(mem_rd_en && sel_ch == $past(sel_ch)));

    assert_read_to_output_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(mem_rd_en, 2) && out_idx == $past(mem_rd_addr, 2)
                       && out_ch == $past(sel_ch, 2)));

    assert_header_sane_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_entry_start) |-> (!out_end_bit && out_size != '0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        assert_error_turns_off_R8: assert property (@(posedge clk) disable iff (rst)
            $rose(ch_err[c]) |-> (ch_state[2*c +: 2] == CH_OFF));

        assert_eof_silent_R5: assert property (@(posedge clk) disable iff (rst)
            (ch_state[2*c +: 2] == CH_EOF) |-> !(out_valid && out_ch == CH_W'(c)));
    end

endmodule

bind dlw_walker dlw_walker_chk #(.NUM_CH(NUM_CH), .MEM_WORDS(MEM_WORDS)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .ch_state        (ch_state),
    .ch_err          (ch_err),
    .mem_rd_en       (mem_rd_en),
    .mem_rd_addr     (mem_rd_addr),
    .sel_ch          (sel_ch),
    .out_valid       (out_valid),
    .out_ch          (out_ch),
    .out_idx         (out_idx),
    .out_end_bit     (out_data[31]),
    .out_size        (out_data[29:24]),
    .out_entry_start (out_entry_start)
);

// File: tb/test_dlw_walker.sv
`timescale 1ns/1ps
module test_dlw_walker;

    localparam int NCH   = 3;
    localparam int WORDS = 4096;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_ch = '0;
    logic [11:0] cfg_start = '0;
    logic        cfg_run = 1'b0;
    logic [5:0]  ch_state;
    logic [2:0]  ch_err;
    logic        mem_rd_en;
    logic [11:0] mem_rd_addr;
    logic [31:0] mem_rd_data;
    logic        out_valid;
    logic [1:0]  out_ch;
    logic [11:0] out_idx;
    logic [31:0] out_data;
    logic        out_entry_start;

    always #2.5 clk = ~clk;   // 200 MHz

    dlw_walker #(.NUM_CH(NCH), .MEM_WORDS(WORDS)) i_dlw_walker (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_start(cfg_start),
        .cfg_run(cfg_run), .ch_state(ch_state), .ch_err(ch_err), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .out_valid(out_valid),
        .out_ch(out_ch), .out_idx(out_idx), .out_data(out_data),
        .out_entry_start(out_entry_start)
    );

    // List memory with one cycle of read latency
    logic [31:0] mem [WORDS];
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int go_cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Reference: expected words per channel (idx | start<<16), final mode/error
    int exp_q [NCH][$];
    int exp_mode [NCH];
    bit exp_err [NCH];
    int rr_log [$];
    int gap_log [$];
    int first_out [NCH];
    int last_out [NCH];

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] hdr_word(int size, bit last);
        return {last, 1'b0, 6'(size), 24'h00C0DE};
    endfunction

    task automatic put_entry(int at, int size);
        mem[at] = hdr_word(size, 1'b0);
        for (int k = 1; k < size; k++) mem[at + k] = 32'h0055_0000 + 32'(at + k);
    endtask

    task automatic put_end(int at);
        mem[at] = hdr_word(0, 1'b1);
    endtask

    // Independent list walk from the header format of R3
    function automatic void expect_walk(int ch, int start);
        int a;
        int sz;
        logic [31:0] w;
        a = start;
        exp_q[ch].delete();
        exp_err[ch] = 1'b0;
        exp_mode[ch] = 0;
        for (int guard = 0; guard < WORDS; guard++) begin
            w = mem[a];
            sz = int'(w[29:24]);
            if (w[31]) begin exp_mode[ch] = 2; return; end
            if (sz == 0 || a + sz > WORDS - 1) begin exp_err[ch] = 1'b1; return; end
            exp_q[ch].push_back(a | (1 << 16));
            for (int k = 1; k < sz; k++) exp_q[ch].push_back(a + k);
            a += sz;
        end
    endfunction

    task automatic cfg_write(int ch, int start, bit run);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_start = 12'(start); cfg_run = run;
        go_cyc = cyc;
    endtask

    task automatic cfg_idle();
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    function automatic bit any_walk();
        for (int c = 0; c < NCH; c++) if (ch_state[2*c +: 2] == 2'd1) return 1'b1;
        return 1'b0;
    endfunction

    task automatic wait_quiet();
        for (int n = 0; n < 3000 && any_walk(); n++) @(posedge clk);
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic reset_trk();
        rr_log.delete();
        gap_log.delete();
        for (int c = 0; c < NCH; c++) begin first_out[c] = -1; last_out[c] = -1; end
    endtask

    task automatic check_final(int ch, string tag);
        chk(exp_q[ch].size() == 0, tag, $sformatf("ch%0d words still expected", ch),
            exp_q[ch].size(), 0);
        chk(int'(ch_state[2*ch +: 2]) == exp_mode[ch], tag,
            $sformatf("ch%0d final mode", ch), int'(ch_state[2*ch +: 2]), exp_mode[ch]);
        chk(ch_err[ch] == exp_err[ch], tag, $sformatf("ch%0d error flag", ch),
            int'(ch_err[ch]), int'(exp_err[ch]));
    endtask

    // Output monitor, compared against the expected streams on every clock
    always @(negedge clk) begin
        int c;
        int e;
        int eidx;
        bit est;
        string tg;
        if (!rst && out_valid) begin
            c = int'(out_ch);
            checks++;
            if (c >= NCH) begin
                errors++;
                $display("FAIL R2 word on channel index: actual=%0d expected=<%0d", c, NCH);
            end else if (exp_q[c].size() == 0) begin
                errors++;
                $display("FAIL R5 unexpected word ch%0d idx %0d: actual=1 expected=0",
                         c, out_idx);
            end else begin
                e = exp_q[c].pop_front();
                eidx = e & 16'hFFFF;
                est = ((e >> 16) & 1) != 0;
                tg = (mem[eidx][31] && !est) ? "R4" : "R3";
                if (out_idx != 12'(eidx) || out_entry_start != est || out_data != mem[eidx]) begin
                    errors++;
                    $display("FAIL %s ch%0d word: actual=idx %0d start %0d data %h expected=idx %0d start %0d data %h",
                             tg, c, out_idx, out_entry_start, out_data, eidx, est, mem[eidx]);
                end
                rr_log.push_back(c);
                if (last_out[c] >= 0) gap_log.push_back(cyc - last_out[c]);
                if (first_out[c] < 0) first_out[c] = cyc;
                last_out[c] = cyc;
            end
        end
    end

    // Watchdog
    initial begin
        #(100000 * 5);
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [5:0] st_snap;
        logic [2:0] er_snap;
        int bad;
        for (int i = 0; i < WORDS; i++) mem[i] = '0;
        reset_trk();
        for (int c = 0; c < NCH; c++) begin exp_mode[c] = 0; exp_err[c] = 1'b0; end

        // R1: reset state
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(ch_state == '0, "R1", "modes after reset", int'(ch_state), 0);
        chk(ch_err == '0, "R1", "errors after reset", int'(ch_err), 0);
        chk(!out_valid && !mem_rd_en, "R1", "activity after reset",
            int'({out_valid, mem_rd_en}), 0);

        // S1: chained entries, body word with bit 31 set, size-1 entry (R3, R4, R5, R9, R10)
        put_entry(40, 3);
        mem[42] = 32'hFF00_1234;
        put_entry(43, 1);
        put_entry(44, 4);
        put_end(48);
        expect_walk(0, 40);
        reset_trk();
        cfg_write(0, 40, 1'b1);
        bad = go_cyc;
        cfg_idle();
        wait_quiet();
        check_final(0, "R5");
        chk(first_out[0] - bad == 3, "R10", "cycles from run write to first word",
            first_out[0] - bad, 3);
        foreach (gap_log[i]) chk(gap_log[i] == 2, "R9", "single-channel word spacing", gap_log[i], 2);

        // S2: three channels, one starting in the reserved low words (R9, R2)
        put_entry(0, 12);  put_end(12);
        put_entry(100, 12); put_end(112);
        put_entry(200, 12); put_end(212);
        expect_walk(0, 0);
        expect_walk(1, 100);
        expect_walk(2, 200);
        reset_trk();
        cfg_write(0, 0, 1'b1);
        cfg_write(1, 100, 1'b1);
        cfg_write(2, 200, 1'b1);
        cfg_idle();
        wait_quiet();
        for (int c = 0; c < NCH; c++) check_final(c, "R3");
        chk(rr_log.size() >= 9, "R9", "words logged", rr_log.size(), 9);
        for (int i = 0; i < 9 && i < rr_log.size(); i++)
            chk(rr_log[i] == i % 3, "R9", $sformatf("round-robin order pos %0d", i), rr_log[i], i % 3);

        // S3: zero-size header (R7)
        put_entry(300, 2);
        mem[302] = hdr_word(0, 1'b0);
        expect_walk(1, 300);
        cfg_write(1, 300, 1'b1);
        cfg_idle();
        wait_quiet();
        check_final(1, "R7");

        // S4: entry ending at last word, then overrun (R8)
        put_entry(4093, 2);
        put_end(4095);
        expect_walk(2, 4093);
        cfg_write(2, 4093, 1'b1);
        cfg_idle();
        wait_quiet();
        check_final(2, "R8");
        mem[4095] = hdr_word(1, 1'b0);
        expect_walk(2, 4095);
        cfg_write(2, 4095, 1'b1);
        cfg_idle();
        wait_quiet();
        check_final(2, "R8");

        // S5: stop a walk in progress; no reads afterwards (R2, R6)
        put_entry(500, 60);
        put_end(560);
        expect_walk(0, 500);
        cfg_write(0, 500, 1'b1);
        cfg_idle();
        repeat (8) @(posedge clk);
        cfg_write(0, 500, 1'b0);
        cfg_idle();
        exp_q[0].delete();
        exp_mode[0] = 0;
        exp_err[0] = 1'b0;
        for (int n = 0; n < 10; n++) begin
            @(negedge clk);
            chk(!mem_rd_en, "R6", "read while no channel walks", int'(mem_rd_en), 0);
        end
        check_final(0, "R2");

        // S6: write to a channel index with no channel is ignored (R2)
        st_snap = ch_state;
        er_snap = ch_err;
        cfg_write(3, 40, 1'b1);
        cfg_idle();
        repeat (6) @(negedge clk);
        chk(ch_state == st_snap, "R2", "modes after write to absent channel",
            int'(ch_state), int'(st_snap));
        chk(ch_err == er_snap, "R2", "errors after write to absent channel",
            int'(ch_err), int'(er_snap));

        // S7: restart a faulted channel and a stopped one on the same list (R2)
        expect_walk(0, 40);
        expect_walk(1, 40);
        cfg_write(1, 40, 1'b1);
        cfg_write(0, 40, 1'b1);
        cfg_idle();
        wait_quiet();
        check_final(0, "R2");
        check_final(1, "R2");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule